// File: doc/BRIEF.md
# Triggered Command Set Engine

The engine holds a small number of command sets. Each set has a fixed number of command slots, and each slot holds a message ID, an address and a data word. Software fills the slots through a register port. It marks which slots are live with a per-set enable mask and marks which slots need a completion response with a per-set wait mask. It then starts the set with a two-step control handshake. The set issues its live slots one by one on a request/acknowledge bus. It records per slot whether the slot was issued and whether it completed, and it captures the response data.

When a set has issued every live slot and has received every completion it asked for, it drops back to idle and latches a per-set interrupt status bit. A shared interrupt line goes high when any latched bit is also enabled. Software drops a latched bit by writing 1 to it in the clear register. When several sets run at once, they share the request bus by fixed priority. A stalled request keeps the bus until it is accepted.

Top module: `tcs_engine`

## Requirements
- R1: Set s occupies register offsets s*672 up to s*672+671. Within a set, the wait mask is at +0x10, control at +0x14, status at +0x18 and the enable mask at +0x1C. Slot c starts at +0x30+20*c and holds message ID (+0), address (+4), data (+8), slot status (+12) and response data (+16). Message ID, address, data and both masks read back what was written.
- R2: A set starts only on a register write that takes control bit 24 from 0 to 1 while control bit 16 was already 1 before that write. A single write that sets both bits from 0 does not start the set.
- R3: The set status register reads 1 while the set is idle and 0 while it is running. After reset every set is idle.
- R4: A running set issues the slots whose enable bit is 1, in ascending slot order, one request at a time. Each request holds until req_ready is seen. req_tag carries the set index in its upper bits and the slot index in its low bits. req_msgid, req_addr and req_data carry the slot's stored words.
- R5: A slot whose wait bit is 1 must receive a response before the set can finish. A response matches a slot when rsp_valid is high with rsp_tag equal to that slot's tag. The set stays busy until that response arrives.
- R6: Slot status bit 8 is set when the slot's request is accepted. Slot status bit 16 is set when its response arrives, and the response data is stored at +16. A start clears both status bits of all slots in the set.
- R7: When a set finishes, the interrupt status register (+0x04) gets that set's bit. The irq output is high while any status bit is also set in the interrupt enable register (+0x00).
- R8: Writing 1s to the clear register (+0x08) drops the matching interrupt status bits at that clock edge.
- R9: A trigger written while the set is running is ignored. It causes neither a second run nor an extra request.
- R10: When several sets are requesting, the lowest set index wins the bus. A request that is stalled by a low req_ready keeps the bus until it is accepted.
- R11: After reset, irq, req_valid and all interrupt enable and status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| req_valid | output | 1 | Command request valid |
| req_ready | input | 1 | Downstream accepts the request |
| req_tag | output | SET_W+CMD_W | Set index and slot index of the request |
| req_msgid | output | 32 | Slot message ID |
| req_addr | output | 32 | Slot address word |
| req_data | output | 32 | Slot data word |
| rsp_valid | input | 1 | Completion response valid |
| rsp_tag | input | SET_W+CMD_W | Tag of the completing slot |
| rsp_data | input | 32 | Response data |
| irq | output | 1 | Combined done interrupt |

## Verification
The hardest case to reach from the ports is a bus stall with two sets contending for the bus. The bench starts the higher-numbered set while req_ready is held low, then starts the lower-numbered set, and checks that the stalled tag does not move. It then releases req_ready and lets the scoreboard check the interleaved issue order. A second hard case is the window where every request has been accepted but a required completion is still outstanding. The bench reaches it by holding back the response and issuing a fresh trigger inside that window. It then checks that the set still reads busy, that no extra request appears, and that the set finishes exactly once when the response finally arrives.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
    localparam int SET_STRIDE  = 672;
    localparam int OFF_W       = $clog2(SET_STRIDE);
    localparam int CMD_BASE    = 48;
    localparam int CMD_STRIDE  = 20;

    localparam int OFF_WAIT    = 16;
    localparam int OFF_CTRL    = 20;
    localparam int OFF_STAT    = 24;
    localparam int OFF_CMDEN   = 28;

    localparam int COM_IRQ_EN  = 0;
    localparam int COM_IRQ_STS = 4;
    localparam int COM_IRQ_CLR = 8;
    localparam int COM_END     = 16;

    localparam int FLD_MSGID   = 0;
    localparam int FLD_ADDR    = 4;
    localparam int FLD_DATA    = 8;
    localparam int FLD_STAT    = 12;
    localparam int FLD_RESP    = 16;

    localparam int CTRL_EN_BIT    = 16;
    localparam int CTRL_TRIG_BIT  = 24;
    localparam int CST_ISSUED_BIT = 8;
    localparam int CST_DONE_BIT   = 16;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic [31:0] msgid;
        logic [31:0] addr;
        logic [31:0] data;
    } cmd_entry_t;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/tcs_set.sv
module tcs_set
    import tcs_pkg::*;
#(
    parameter int NUM_CMDS = 4,
    localparam int CMD_W = idx_w(NUM_CMDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] off,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic             ack,
    input  logic             rsp_hit,
    input  logic [CMD_W-1:0] rsp_cmd,
    input  logic [31:0]      rsp_data,
    output logic             req_valid,
    output logic [CMD_W-1:0] req_cmd,
    output cmd_entry_t       req_entry,
    output logic             done
);
    cmd_entry_t          ent_q  [NUM_CMDS];
    logic [31:0]         resp_q [NUM_CMDS];
    logic [NUM_CMDS-1:0] issued_q, compl_q, wait_q, cmden_q, pend_q, left_q;
    logic                en_q, trig_q;
    seq_state_e          st_q;

    logic                slot_hit;
    logic [CMD_W-1:0]    slot_idx;
    logic [4:0]          slot_fld;
    logic                start;

    // Map an in-set offset onto a slot index and a field offset.
    function automatic logic slot_decode(input logic [OFF_W-1:0] o,
                                         output logic [CMD_W-1:0] idx,
                                         output logic [4:0] fld);
        slot_decode = 1'b0;
        idx = '0;
        fld = '0;
        for (int c = 0; c < NUM_CMDS; c++) begin
            if (int'(o) >= CMD_BASE + c*CMD_STRIDE &&
                int'(o) <  CMD_BASE + (c+1)*CMD_STRIDE) begin
                slot_decode = 1'b1;
                idx = CMD_W'(c);
                fld = 5'(int'(o) - CMD_BASE - c*CMD_STRIDE);
            end
        end
    endfunction

    always_comb slot_hit = slot_decode(off, slot_idx, slot_fld);

    // Rising trigger with mode already enabled, only when idle.
    assign start = wr_en && (int'(off) == OFF_CTRL) && wdata[CTRL_TRIG_BIT]
                   && !trig_q && en_q && (st_q == SEQ_IDLE);

    // Lowest pending slot goes next.
    always_comb begin
        req_cmd = '0;
        for (int c = NUM_CMDS-1; c >= 0; c--)
            if (pend_q[c]) req_cmd = CMD_W'(c);
    end

    assign req_valid = (st_q == SEQ_RUN) && (|pend_q);
    assign req_entry = ent_q[req_cmd];
    assign done      = (st_q == SEQ_RUN) && (pend_q == '0) && (left_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NUM_CMDS; c++) begin
                ent_q[c]  <= '0;
                resp_q[c] <= '0;
            end
            issued_q <= '0;
            compl_q  <= '0;
            wait_q   <= '0;
            cmden_q  <= '0;
            pend_q   <= '0;
            left_q   <= '0;
            en_q     <= 1'b0;
            trig_q   <= 1'b0;
            st_q     <= SEQ_IDLE;
        end else begin
            if (wr_en) begin
                if (slot_hit) begin
                    case (int'(slot_fld))
                        FLD_MSGID: ent_q[slot_idx].msgid <= wdata;
                        FLD_ADDR:  ent_q[slot_idx].addr  <= wdata;
                        FLD_DATA:  ent_q[slot_idx].data  <= wdata;
                        default: ;
                    endcase
                end else begin
                    case (int'(off))
                        OFF_WAIT:  wait_q  <= wdata[NUM_CMDS-1:0];
                        OFF_CMDEN: cmden_q <= wdata[NUM_CMDS-1:0];
                        OFF_CTRL: begin
                            en_q   <= wdata[CTRL_EN_BIT];
                            trig_q <= wdata[CTRL_TRIG_BIT];
                        end
                        default: ;
                    endcase
                end
            end
            if (start) begin
                st_q     <= SEQ_RUN;
                pend_q   <= cmden_q;
                left_q   <= cmden_q & wait_q;
                issued_q <= '0;
                compl_q  <= '0;
            end else if (st_q == SEQ_RUN) begin
                if (done) st_q <= SEQ_IDLE;
                if (ack) begin
                    pend_q[req_cmd]   <= 1'b0;
                    issued_q[req_cmd] <= 1'b1;
                end
                if (rsp_hit && !pend_q[rsp_cmd]) begin
                    left_q[rsp_cmd]  <= 1'b0;
                    compl_q[rsp_cmd] <= 1'b1;
                    resp_q[rsp_cmd]  <= rsp_data;
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (slot_hit) begin
            case (int'(slot_fld))
                FLD_MSGID: rdata = ent_q[slot_idx].msgid;
                FLD_ADDR:  rdata = ent_q[slot_idx].addr;
                FLD_DATA:  rdata = ent_q[slot_idx].data;
                FLD_STAT: begin
                    rdata[CST_ISSUED_BIT] = issued_q[slot_idx];
                    rdata[CST_DONE_BIT]   = compl_q[slot_idx];
                end
                FLD_RESP:  rdata = resp_q[slot_idx];
                default: ;
            endcase
        end else begin
            case (int'(off))
                OFF_WAIT:  rdata = 32'(wait_q);
                OFF_CMDEN: rdata = 32'(cmden_q);
                OFF_STAT:  rdata = {31'd0, st_q == SEQ_IDLE};
                OFF_CTRL: begin
                    rdata[CTRL_EN_BIT]   = en_q;
                    rdata[CTRL_TRIG_BIT] = trig_q;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tcs_arb.sv
module tcs_arb #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         ready,
    output logic [N-1:0] grant
);
    logic [N-1:0] pick, held_q;
    logic         lock_q;

    always_comb begin
        pick = '0;
        for (int i = N-1; i >= 0; i--) begin
            if (req[i]) begin
                pick    = '0;
                pick[i] = 1'b1;
            end
        end
    end

    assign grant = lock_q ? held_q : pick;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
            held_q <= '0;
        end else begin
            lock_q <= (|grant) && !ready;
            held_q <= grant;
        end
    end
endmodule

// File: rtl/tcs_engine.sv
module tcs_engine
    import tcs_pkg::*;
#(
    parameter int NUM_SETS = 2,
    parameter int NUM_CMDS = 4,
    parameter int ADDR_W   = 12,
    localparam int SET_W = idx_w(NUM_SETS),
    localparam int CMD_W = idx_w(NUM_CMDS),
    localparam int TAG_W = SET_W + CMD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [TAG_W-1:0]  req_tag,
    output logic [31:0]       req_msgid,
    output logic [31:0]       req_addr,
    output logic [31:0]       req_data,
    input  logic              rsp_valid,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic [31:0]       rsp_data,
    output logic              irq
);
    logic [NUM_SETS-1:0] in_rng, rsp_hit, ack, set_req, grant_vec, done_vec, clr_vec;
    logic [NUM_SETS-1:0] irq_en_q, irq_sts_q;
    logic [OFF_W-1:0]    set_off   [NUM_SETS];
    logic [31:0]         set_rdata [NUM_SETS];
    logic [CMD_W-1:0]    set_cmd   [NUM_SETS];
    cmd_entry_t          set_ent   [NUM_SETS];
    cmd_entry_t          sel_ent;
    logic                com_sel;

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        localparam int LO = s * SET_STRIDE;
        assign in_rng[s]  = (int'(reg_addr) >= LO) && (int'(reg_addr) < LO + SET_STRIDE);
        assign set_off[s] = OFF_W'(int'(reg_addr) - LO);
        assign rsp_hit[s] = rsp_valid && (int'(rsp_tag[TAG_W-1:CMD_W]) == s);
        assign ack[s]     = grant_vec[s] & req_ready;

        tcs_set #(.NUM_CMDS(NUM_CMDS)) u_set (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (reg_wr && in_rng[s]),
            .off      (set_off[s]),
            .wdata    (reg_wdata),
            .rdata    (set_rdata[s]),
            .ack      (ack[s]),
            .rsp_hit  (rsp_hit[s]),
            .rsp_cmd  (rsp_tag[CMD_W-1:0]),
            .rsp_data (rsp_data),
            .req_valid(set_req[s]),
            .req_cmd  (set_cmd[s]),
            .req_entry(set_ent[s]),
            .done     (done_vec[s])
        );
    end

    tcs_arb #(.N(NUM_SETS)) u_arb (
        .clk  (clk),
        .rst  (rst),
        .req  (set_req),
        .ready(req_ready),
        .grant(grant_vec)
    );

    always_comb begin
        req_tag = '0;
        sel_ent = '0;
        for (int s = 0; s < NUM_SETS; s++) begin
            if (grant_vec[s]) begin
                req_tag = {SET_W'(s), set_cmd[s]};
                sel_ent = set_ent[s];
            end
        end
    end

    assign req_valid = |grant_vec;
    assign req_msgid = sel_ent.msgid;
    assign req_addr  = sel_ent.addr;
    assign req_data  = sel_ent.data;

    // Shared interrupt registers below the first set's own registers.
    assign com_sel = int'(reg_addr) < COM_END;
    assign clr_vec = (reg_wr && int'(reg_addr) == COM_IRQ_CLR) ? reg_wdata[NUM_SETS-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_en_q  <= '0;
            irq_sts_q <= '0;
        end else begin
            if (reg_wr && int'(reg_addr) == COM_IRQ_EN)
                irq_en_q <= reg_wdata[NUM_SETS-1:0];
            irq_sts_q <= (irq_sts_q & ~clr_vec) | done_vec;
        end
    end

    assign irq = |(irq_sts_q & irq_en_q);

    always_comb begin
        reg_rdata = '0;
        for (int s = 0; s < NUM_SETS; s++)
            if (in_rng[s]) reg_rdata = set_rdata[s];
        if (com_sel) begin
            case (int'(reg_addr))
                COM_IRQ_EN:  reg_rdata = 32'(irq_en_q);
                COM_IRQ_STS: reg_rdata = 32'(irq_sts_q);
                default:     reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tcs_engine_chk.sv
module tcs_engine_chk #(
    parameter int NUM_SETS = 2,
    parameter int NUM_CMDS = 4,
    parameter int TAG_W    = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                reg_wr,
    input logic                req_valid,
    input logic                req_ready,
    input logic [TAG_W-1:0]    req_tag,
    input logic [NUM_SETS-1:0] grant_vec,
    input logic [NUM_SETS-1:0] done_vec,
    input logic [NUM_SETS-1:0] clr_vec,
    input logic [NUM_SETS-1:0] irq_sts_q
);
    // R10: a stalled request keeps the bus and its tag
    assert_stall_holds_R10: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_tag));

    // R10: at most one set owns the bus
    assert_single_grant_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_vec));

    // R2: a new burst of requests only follows a register write
    assert_start_from_write_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid) |-> $past(reg_wr));

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_chk
        // R7: finishing latches the interrupt status bit
        assert_done_latches_R7: assert property (@(posedge clk) disable iff (rst)
            done_vec[s] |=> irq_sts_q[s]);

        // R8: write-1-to-clear drops the bit when no new finish competes
        assert_clear_drops_R8: assert property (@(posedge clk) disable iff (rst)
            clr_vec[s] && !done_vec[s] |=> !irq_sts_q[s]);
    end
endmodule

bind tcs_engine tcs_engine_chk #(
    .NUM_SETS(NUM_SETS),
    .NUM_CMDS(NUM_CMDS),
    .TAG_W   (TAG_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_tag  (req_tag),
    .grant_vec(grant_vec),
    .done_vec (done_vec),
    .clr_vec  (clr_vec),
    .irq_sts_q(irq_sts_q)
);

// File: tb/tb_tcs_engine.sv
module tb_tcs_engine;
    localparam int NS = 2;
    localparam int NC = 4;
    localparam int AW = 12;
    localparam int CW = 2;
    localparam int TW = 3;

    logic          clk, rst, reg_wr, req_valid, req_ready, rsp_valid, irq;
    logic [AW-1:0] reg_addr;
    logic [31:0]   reg_wdata, reg_rdata, req_msgid, req_addr, req_data, rsp_data;
    logic [TW-1:0] req_tag, rsp_tag;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int acc_cnt = 0;
    int ready_mode = 0;
    bit auto_rsp = 1'b1;
    bit done_flag = 1'b0;

    typedef struct {
        logic [TW-1:0] tag;
        logic [31:0]   msgid;
        logic [31:0]   addr;
        logic [31:0]   data;
        bit            wt;
    } exp_t;

    exp_t          sbq[$];
    logic [TW-1:0] rspq[$];
    exp_t          mon_e;

    tcs_engine #(.NUM_SETS(NS), .NUM_CMDS(NC), .ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_tag(req_tag), .req_msgid(req_msgid),
        .req_addr(req_addr), .req_data(req_data), .rsp_valid(rsp_valid),
        .rsp_tag(rsp_tag), .rsp_data(rsp_data), .irq(irq)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    function automatic logic [AW-1:0] set_a(input int s, input int o);
        return AW'(s*672 + o);
    endfunction
    function automatic logic [AW-1:0] cmd_a(input int s, input int c, input int f);
        return AW'(s*672 + 48 + c*20 + f);
    endfunction
    function automatic logic [31:0] f_msgid(input int s, input int c);
        return 32'h0001_0008 | (32'(s) << 28) | (32'(c) << 24);
    endfunction
    function automatic logic [31:0] f_addr(input int s, input int c);
        return 32'h0000_3000 + 32'(s*256 + c*16);
    endfunction
    function automatic logic [31:0] f_data(input int s, input int c);
        return 32'hD000_0000 + 32'(s*4096 + c);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic program_set(input int s);
        for (int c = 0; c < NC; c++) begin
            wr(cmd_a(s, c, 0), f_msgid(s, c));
            wr(cmd_a(s, c, 4), f_addr(s, c));
            wr(cmd_a(s, c, 8), f_data(s, c));
        end
    endtask

    // Driver side of the scoreboard.
    task automatic expect_cmd(input int s, input int c, input bit wt);
        exp_t e;
        e.tag = TW'(s*NC + c);
        e.msgid = f_msgid(s, c);
        e.addr = f_addr(s, c);
        e.data = f_data(s, c);
        e.wt = wt;
        sbq.push_back(e);
    endtask

    task automatic wait_idle(input int s);
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(set_a(s, 24), v);
            if (v == 32'd1) break;
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Monitor side of the scoreboard: accepted requests, in order (R4).
    always @(posedge clk) begin
        if (!rst && req_valid && req_ready) begin
            acc_cnt++;
            checks++;
            if (sbq.size() == 0) begin
                failures++;
                $display("FAIL R4 unexpected request actual tag=%h expected none", req_tag);
            end else begin
                mon_e = sbq.pop_front();
                if (req_tag !== mon_e.tag || req_msgid !== mon_e.msgid ||
                    req_addr !== mon_e.addr || req_data !== mon_e.data) begin
                    failures++;
                    $display("FAIL R4 request actual tag=%h addr=%h data=%h msgid=%h expected tag=%h addr=%h data=%h msgid=%h",
                             req_tag, req_addr, req_data, req_msgid,
                             mon_e.tag, mon_e.addr, mon_e.data, mon_e.msgid);
                end
                if (auto_rsp && mon_e.wt) rspq.push_back(mon_e.tag);
            end
        end
    end

    // Response model and ready pattern.
    always @(negedge clk) begin
        if (rspq.size() > 0) begin
            rsp_tag   = rspq.pop_front();
            rsp_data  = 32'hA000_0000 | 32'(rsp_tag);
            rsp_valid = 1'b1;
        end else begin
            rsp_valid = 1'b0;
        end
        case (ready_mode)
            0: req_ready = 1'b0;
            1: req_ready = 1'b1;
            default: req_ready = (cycles % 3) != 0;
        endcase
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 60000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<60000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        int base;
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        req_ready = 1'b0; rsp_valid = 1'b0; rsp_tag = '0; rsp_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 / R3: reset state
        rd(set_a(0, 24), v); chk("R3 set0 idle after reset", v, 32'd1);
        rd(set_a(1, 24), v); chk("R3 set1 idle after reset", v, 32'd1);
        rd(AW'(4), v);       chk("R11 irq status reset", v, 32'd0);
        rd(AW'(0), v);       chk("R11 irq enable reset", v, 32'd0);
        chk("R11 irq low", 32'(irq), 32'd0);
        chk("R11 req_valid low", 32'(req_valid), 32'd0);

        // R1: register map readback
        wr(AW'(0), 32'h3);
        program_set(0);
        wr(set_a(0, 28), 32'hB);
        rd(cmd_a(0, 2, 4), v); chk("R1 slot addr readback", v, f_addr(0, 2));
        rd(cmd_a(0, 3, 8), v); chk("R1 slot data readback", v, f_data(0, 3));
        rd(cmd_a(0, 1, 0), v); chk("R1 slot msgid readback", v, f_msgid(0, 1));
        rd(set_a(0, 28), v);   chk("R1 enable mask readback", v, 32'hB);

        // R2: trigger without prior mode enable does not start
        wr(set_a(0, 20), 32'h0100_0000);
        rd(set_a(0, 24), v); chk("R2 trigger alone no start", v, 32'd1);
        wr(set_a(0, 20), 32'h0101_0000);
        rd(set_a(0, 24), v); chk("R2 both bits in one write no start", v, 32'd1);
        chk("R2 no request", 32'(acc_cnt), 32'd0);

        // R4: proper handshake, slots 0,1,3 in order with an uneven ready pattern
        wr(set_a(0, 20), 32'h0001_0000);
        expect_cmd(0, 0, 0); expect_cmd(0, 1, 0); expect_cmd(0, 3, 0);
        ready_mode = 2;
        wr(set_a(0, 20), 32'h0101_0000);
        rd(set_a(0, 24), v); chk("R3 busy reads 0", v, 32'd0);
        wait_idle(0);
        chk("R4 all enabled slots issued", 32'(sbq.size()), 32'd0);
        rd(AW'(4), v); chk("R7 irq status set0", v, 32'd1);
        chk("R7 irq high", 32'(irq), 32'd1);
        rd(cmd_a(0, 0, 12), v); chk("R6 slot0 issued", v, 32'h100);
        rd(cmd_a(0, 2, 12), v); chk("R6 disabled slot untouched", v, 32'h0);
        rd(cmd_a(0, 3, 12), v); chk("R6 slot3 issued", v, 32'h100);

        // R8: write-1-to-clear
        wr(AW'(8), 32'h1);
        rd(AW'(4), v); chk("R8 status cleared", v, 32'd0);
        chk("R8 irq low after clear", 32'(irq), 32'd0);

        // R5 / R9: completion wait, trigger while busy
        program_set(1);
        wr(set_a(1, 16), 32'h4);
        wr(set_a(1, 28), 32'h5);
        wr(set_a(1, 20), 32'h0001_0000);
        auto_rsp = 1'b0;
        ready_mode = 1;
        expect_cmd(1, 0, 0); expect_cmd(1, 2, 1);
        wr(set_a(1, 20), 32'h0101_0000);
        repeat (10) @(negedge clk);
        chk("R4 set1 slots issued", 32'(sbq.size()), 32'd0);
        rd(set_a(1, 24), v); chk("R5 busy until response", v, 32'd0);
        rd(AW'(4), v); chk("R5 no finish before response", v, 32'd0);
        rd(cmd_a(1, 2, 12), v); chk("R6 issued not completed", v, 32'h100);
        base = acc_cnt;
        wr(set_a(1, 20), 32'h0001_0000);
        wr(set_a(1, 20), 32'h0101_0000);
        rspq.push_back(TW'(1*NC + 2));
        repeat (5) @(negedge clk);
        rd(set_a(1, 24), v); chk("R5 idle after response", v, 32'd1);
        rd(cmd_a(1, 2, 12), v); chk("R6 issued and completed", v, 32'h10100);
        rd(cmd_a(1, 2, 16), v); chk("R6 response data", v, 32'hA000_0006);
        rd(AW'(4), v); chk("R7 irq status set1", v, 32'd2);
        repeat (10) @(negedge clk);
        chk("R9 busy trigger ignored", 32'(acc_cnt - base), 32'd0);
        rd(set_a(1, 24), v); chk("R9 no second run", v, 32'd1);
        wr(AW'(8), 32'h3);

        // R10: priority and stall hold
        auto_rsp = 1'b1;
        ready_mode = 0;
        wr(set_a(1, 20), 32'h0001_0000);
        wr(set_a(0, 20), 32'h0001_0000);
        expect_cmd(1, 0, 0); expect_cmd(0, 0, 0); expect_cmd(0, 1, 0);
        expect_cmd(0, 3, 0); expect_cmd(1, 2, 1);
        wr(set_a(1, 20), 32'h0101_0000);
        wr(set_a(0, 20), 32'h0101_0000);
        repeat (3) @(negedge clk);
        chk("R10 stalled request valid", 32'(req_valid), 32'd1);
        chk("R10 stalled tag kept", 32'(req_tag), 32'd4);
        ready_mode = 1;
        wait_idle(0);
        wait_idle(1);
        chk("R10 interleaved order drained", 32'(sbq.size()), 32'd0);
        rd(AW'(4), v); chk("R10 both sets finished", v, 32'd3);

        finish_run();
    end
endmodule